// File: doc/BRIEF.md
# Target Programming Frame Sequencer

This block sits between a command decoder and a byte-wide serial shifter in an in-system programmer. A one-cycle `start` hands it an operation code, a target class code, a 16-bit address and a data byte. It expands that request into the byte sequence the target expects on its serial programming port. It moves the bytes one at a time over a request/acknowledge byte port, and collects the bytes returned in the read slots. After a write it holds off completion for a wait time that depends on the operation.

Most targets use a four-byte frame: an opcode byte, then the address high and low bytes, then a data or dummy byte. One target class (code 0x86) has byte-wide program memory and a shorter three-byte frame. For that class, bits 4:0 of the address high byte are shifted up three places and merged with a 3-bit operation selector, so the opcode and address share one byte. When the operation ends, `done` pulses for one cycle. `err` marks a rejected request, and `rdata` holds the captured bytes with the earliest byte in the most significant position.

Top module: `prog_frame_seq`

## Requirements
- R1: For a target other than 0x86, op 0 (program write low) sends 0x40, addr[15:8], addr[7:0], data. Op 1 (program write high) sends the same bytes with 0x48 first. Op 3 (data write) sends 0xC0, addr[15:8], addr[7:0], data. Op 4 (data read) sends 0xA0, addr[15:8], addr[7:0], 0x00 and captures the byte returned for the last slot.
- R2: For target 0x86, let P = {addr[12:8],3'b000}. Op 0 sends P|0x02, addr[7:0], data. Op 2 sends P|0x01, addr[7:0], 0x00. Op 3 sends P|0x06, addr[7:0], data. Op 4 sends P|0x05, addr[7:0], 0x00. Each read captures the byte returned for its last slot.
- R3: For a target other than 0x86, op 2 (program read) sends 0x28, ah, al, 0x00 and then 0x20, ah, al, 0x00. The two captured bytes appear as rdata[15:8] (the 0x28 frame) and rdata[7:0]. For target 0x86, the single captured byte appears in rdata[7:0].
- R4: Op 1 for target 0x86, op 7 for target 0x86, and any op code from 10 to 15 are rejected. A rejected request makes no byte transfer, and `done` and `err` are both high two cycles after `start` is sampled.
- R5: For target 0x40, the data byte of op 0 and op 1 is sent inverted. Data writes (op 3) send it unchanged.
- R6: After the last acknowledge of op 0 or op 1, `done` rises WAIT_WR cycles later, or in the next cycle for targets 0x40 and 0x41. After op 3 it always rises WAIT_WR cycles later. After reads it rises in the next cycle.
- R7: Op 5 (chip erase) sends 0xAC, 0x80, 0x04, 0x00. For target 0x86 the 0x80 byte is left out. `done` follows the last acknowledge by WAIT_LONG cycles.
- R8: Op 6 (lock write) sends 0xAC, (data&0x06)|0xE0, 0x00, 0x00. For target 0x86 it sends 0xAC, (data&0xE0)|0x07, 0x00. `done` follows the last acknowledge by WAIT_LONG cycles.
- R9: Op 7 (signature read) sends three frames 0x30, 0x00, k, 0x00 for k = 2, 1, 0 in that order, capturing the fourth byte of each. The result is rdata = {sig2, sig1, sig0}.
- R10: Op 8 (page commit) sends 0x4C, ah, al, 0x00. `done` follows the last acknowledge by WAIT_PAGE cycles.
- R11: Op 9 (raw command) sends addr[15:8], addr[7:0], data unchanged, then 0x00. The byte returned for the fourth slot appears in rdata[7:0], and `done` follows the last acknowledge by WAIT_PAGE cycles.
- R12: `done` is high for exactly one cycle per request, and `rdata` and `err` are held after it. `spi_tx` holds steady while a request waits for its acknowledge. A `start` pulse while an operation is in progress is ignored.
- R13: After reset, `spi_req`, `done` and `err` are low and `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request strobe, sampled when idle |
| op | input | 4 | Operation code |
| target | input | 8 | Target class code |
| addr | input | 16 | Address (raw command: first two bytes) |
| wdata | input | 8 | Data byte (raw command: third byte) |
| spi_req | output | 1 | Byte transfer requested |
| spi_tx | output | 8 | Byte to shift out |
| spi_ack | input | 1 | Transfer finished, one-cycle pulse |
| spi_rx | input | 8 | Byte shifted in, valid with spi_ack |
| done | output | 1 | Operation complete, one-cycle pulse |
| err | output | 1 | Request rejected, valid from done |
| rdata | output | 24 | Captured read bytes, oldest highest |

## Verification
A wrong byte index or a mis-selected frame family shows up at the first acknowledged transfer after the fault. It appears as a wrong `spi_tx` value, or as a byte stream that is too long or too short when `done` arrives. A wrong wait selection or counter load moves `done` by a measurable number of cycles after the final acknowledge. Capture faults show up in `rdata` in the `done` cycle. Because the acknowledge latency is randomized, a handshake that does not hold `spi_tx` or double-advances the index corrupts the logged stream within one frame.

// File: rtl/prog_frame_pkg.sv
package prog_frame_pkg;
  typedef enum logic [3:0] {
    OP_PWR_LO = 4'd0,
    OP_PWR_HI = 4'd1,
    OP_PRD    = 4'd2,
    OP_DWR    = 4'd3,
    OP_DRD    = 4'd4,
    OP_ERASE  = 4'd5,
    OP_LOCK   = 4'd6,
    OP_SIG    = 4'd7,
    OP_PAGE   = 4'd8,
    OP_RAW    = 4'd9
  } op_e;

  typedef enum logic [1:0] {
    W_NONE = 2'd0,
    W_WR   = 2'd1,
    W_LONG = 2'd2,
    W_PAGE = 2'd3
  } wait_e;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_EVAL = 3'd1,
    S_SEND = 3'd2,
    S_WAIT = 3'd3,
    S_FIN  = 3'd4
  } seq_e;

  localparam int unsigned MAX_BYTES = 12;
  localparam int unsigned IDX_W = $clog2(MAX_BYTES);
endpackage

// File: rtl/prog_frame_enc.sv
module prog_frame_enc
  import prog_frame_pkg::*;
(
  input  logic [3:0]       op,
  input  logic             narrow,
  input  logic             inv_data,
  input  logic             page_tgt,
  input  logic [15:0]      addr,
  input  logic [7:0]       data,
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       tx,
  output logic [IDX_W-1:0] last,
  output logic             cap,
  output wait_e            wsel,
  output logic             reject
);
  logic [7:0] ah, al, pk, wd;
  logic [1:0] pos, frm;

  assign ah  = addr[15:8];
  assign al  = addr[7:0];
  assign pk  = {addr[12:8], 3'b000};
  assign wd  = inv_data ? ~data : data;
  assign pos = idx[1:0];
  assign frm = idx[3:2];

  always_comb begin
    tx     = 8'h00;
    last   = IDX_W'(3);
    cap    = 1'b0;
    wsel   = W_NONE;
    reject = 1'b0;
    case (op_e'(op))
      OP_PWR_LO, OP_PWR_HI: begin
        wsel = page_tgt ? W_NONE : W_WR;
        if (narrow) begin
          reject = (op == OP_PWR_HI);
          last   = IDX_W'(2);
          case (pos)
            2'd0:    tx = pk | 8'h02;
            2'd1:    tx = al;
            default: tx = wd;
          endcase
        end else begin
          case (pos)
            2'd0:    tx = (op == OP_PWR_HI) ? 8'h48 : 8'h40;
            2'd1:    tx = ah;
            2'd2:    tx = al;
            default: tx = wd;
          endcase
        end
      end
      OP_PRD: begin
        if (narrow) begin
          last = IDX_W'(2);
          case (pos)
            2'd0:    tx = pk | 8'h01;
            2'd1:    tx = al;
            default: cap = 1'b1;
          endcase
        end else begin
          last = IDX_W'(7);
          case (pos)
            2'd0:    tx = (frm == 2'd0) ? 8'h28 : 8'h20;
            2'd1:    tx = ah;
            2'd2:    tx = al;
            default: cap = 1'b1;
          endcase
        end
      end
      OP_DWR, OP_DRD: begin
        wsel = (op == OP_DWR) ? W_WR : W_NONE;
        if (narrow) begin
          last = IDX_W'(2);
          case (pos)
            2'd0:    tx = pk | ((op == OP_DWR) ? 8'h06 : 8'h05);
            2'd1:    tx = al;
            default: begin
              tx  = (op == OP_DWR) ? data : 8'h00;
              cap = (op == OP_DRD);
            end
          endcase
        end else begin
          case (pos)
            2'd0:    tx = (op == OP_DWR) ? 8'hC0 : 8'hA0;
            2'd1:    tx = ah;
            2'd2:    tx = al;
            default: begin
              tx  = (op == OP_DWR) ? data : 8'h00;
              cap = (op == OP_DRD);
            end
          endcase
        end
      end
      OP_ERASE: begin
        wsel = W_LONG;
        if (narrow) begin
          last = IDX_W'(2);
          case (pos)
            2'd0:    tx = 8'hAC;
            2'd1:    tx = 8'h04;
            default: tx = 8'h00;
          endcase
        end else begin
          case (pos)
            2'd0:    tx = 8'hAC;
            2'd1:    tx = 8'h80;
            2'd2:    tx = 8'h04;
            default: tx = 8'h00;
          endcase
        end
      end
      OP_LOCK: begin
        wsel = W_LONG;
        if (narrow) last = IDX_W'(2);
        case (pos)
          2'd0:    tx = 8'hAC;
          2'd1:    tx = narrow ? ((data & 8'hE0) | 8'h07) : ((data & 8'h06) | 8'hE0);
          default: tx = 8'h00;
        endcase
      end
      OP_SIG: begin
        reject = narrow;
        last   = IDX_W'(11);
        case (pos)
          2'd0:    tx = 8'h30;
          2'd1:    tx = 8'h00;
          2'd2:    tx = {6'd0, 2'd2 - frm};
          default: cap = 1'b1;
        endcase
      end
      OP_PAGE: begin
        wsel = W_PAGE;
        case (pos)
          2'd0:    tx = 8'h4C;
          2'd1:    tx = ah;
          2'd2:    tx = al;
          default: tx = 8'h00;
        endcase
      end
      OP_RAW: begin
        wsel = W_PAGE;
        case (pos)
          2'd0:    tx = ah;
          2'd1:    tx = al;
          2'd2:    tx = data;
          default: cap = 1'b1;
        endcase
      end
      default: reject = 1'b1;
    endcase
  end
endmodule

// File: rtl/prog_wait_timer.sv
module prog_wait_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign expired = (cnt_q == '0);
  assign cnt_en  = load || !expired;

  always_comb begin
    cnt_d = cnt_q;
    if (load)          cnt_d = load_val;
    else if (!expired) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/prog_frame_seq.sv
module prog_frame_seq
  import prog_frame_pkg::*;
#(
  parameter int unsigned WAIT_WR     = 20,
  parameter int unsigned WAIT_LONG   = 40,
  parameter int unsigned WAIT_PAGE   = 60,
  parameter logic [7:0]  NARROW_CODE = 8'h86,
  parameter logic [7:0]  INV_CODE    = 8'h40,
  parameter logic [7:0]  PAGE_CODE_A = 8'h40,
  parameter logic [7:0]  PAGE_CODE_B = 8'h41
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [3:0]  op,
  input  logic [7:0]  target,
  input  logic [15:0] addr,
  input  logic [7:0]  wdata,
  output logic        spi_req,
  output logic [7:0]  spi_tx,
  input  logic        spi_ack,
  input  logic [7:0]  spi_rx,
  output logic        done,
  output logic        err,
  output logic [23:0] rdata
);
  localparam int unsigned MAX_W0 = (WAIT_WR > WAIT_LONG) ? WAIT_WR : WAIT_LONG;
  localparam int unsigned MAX_W  = (MAX_W0 > WAIT_PAGE) ? MAX_W0 : WAIT_PAGE;
  localparam int unsigned CNT_W  = $clog2(MAX_W + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_m, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  seq_e             state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [23:0]      rd_q, rd_d;
  logic             err_q, err_d;
  logic [3:0]       op_q;
  logic [7:0]       tgt_q, data_q;
  logic [15:0]      addr_q;
  logic             lat_en;

  logic [7:0]       enc_tx;
  logic [IDX_W-1:0] enc_last;
  logic             enc_cap, enc_rej;
  wait_e            enc_wsel;
  logic [CNT_W-1:0] wlen;
  logic             t_load, t_exp;

  prog_frame_enc u_enc (
    .op       (op_q),
    .narrow   (tgt_q == NARROW_CODE),
    .inv_data (tgt_q == INV_CODE),
    .page_tgt ((tgt_q == PAGE_CODE_A) || (tgt_q == PAGE_CODE_B)),
    .addr     (addr_q),
    .data     (data_q),
    .idx      (idx_q),
    .tx       (enc_tx),
    .last     (enc_last),
    .cap      (enc_cap),
    .wsel     (enc_wsel),
    .reject   (enc_rej)
  );

  always_comb begin
    case (enc_wsel)
      W_WR:    wlen = CNT_W'(WAIT_WR);
      W_LONG:  wlen = CNT_W'(WAIT_LONG);
      W_PAGE:  wlen = CNT_W'(WAIT_PAGE);
      default: wlen = '0;
    endcase
  end

  prog_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_s),
    .load     (t_load),
    .load_val (wlen - 1'b1),
    .expired  (t_exp)
  );

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    rd_d    = rd_q;
    err_d   = err_q;
    lat_en  = 1'b0;
    t_load  = 1'b0;
    case (state_q)
      S_IDLE: if (start) begin
        lat_en  = 1'b1;
        idx_d   = '0;
        rd_d    = '0;
        err_d   = 1'b0;
        state_d = S_EVAL;
      end
      S_EVAL: begin
        err_d   = enc_rej;
        state_d = enc_rej ? S_FIN : S_SEND;
      end
      S_SEND: if (spi_ack) begin
        if (enc_cap) rd_d = {rd_q[15:0], spi_rx};
        if (idx_q == enc_last) begin
          t_load  = (wlen != '0);
          state_d = (wlen != '0) ? S_WAIT : S_FIN;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      S_WAIT:  if (t_exp) state_d = S_FIN;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      rd_q    <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      rd_q    <= rd_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk) begin
    if (lat_en) begin
      op_q   <= op;
      tgt_q  <= target;
      addr_q <= addr;
      data_q <= wdata;
    end
  end

  assign spi_req = (state_q == S_SEND);
  assign spi_tx  = enc_tx;
  assign done    = (state_q == S_FIN);
  assign err     = err_q;
  assign rdata   = rd_q;

  a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_s)
    done |=> !done);
  a_r12_tx_held: assert property (@(posedge clk) disable iff (!rst_s)
    (spi_req && !spi_ack) |=> (spi_req && $stable(spi_tx)));
  a_r12_busy_ignores_start: assert property (@(posedge clk) disable iff (!rst_s)
    (state_q != S_IDLE) |=> $stable(op_q));
  a_r4_reject_no_xfer: assert property (@(posedge clk) disable iff (!rst_s)
    (state_q == S_EVAL && enc_rej) |=> (done && err && !spi_req));
  a_r6_wait_holds: assert property (@(posedge clk) disable iff (!rst_s)
    (state_q == S_WAIT && !t_exp) |=> (state_q == S_WAIT && !spi_req));
endmodule

// File: tb/tb_prog_frame_seq.sv
module tb_prog_frame_seq;
  localparam int CLK_P = 10;
  localparam int WR = 20, LONG = 40, PAGE = 60;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, spi_ack = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] tgt_i = '0, wd_i = '0, spi_rx = '0, spi_tx;
  logic [15:0] addr_i = '0;
  logic spi_req, done, err;
  logic [23:0] rdata;

  always #(CLK_P/2) clk = ~clk;

  prog_frame_seq #(.WAIT_WR(WR), .WAIT_LONG(LONG), .WAIT_PAGE(PAGE)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op_i), .target(tgt_i),
    .addr(addr_i), .wdata(wd_i), .spi_req(spi_req), .spi_tx(spi_tx),
    .spi_ack(spi_ack), .spi_rx(spi_rx), .done(done), .err(err), .rdata(rdata));

  int n_run = 0, n_fail = 0, cyc = 0, ack_cyc = 0, got_n = 0;
  logic [7:0] got_tx [0:15];
  logic [7:0] got_rx [0:15];
  logic [7:0] exp_b [0:15];
  bit exp_c [0:15];
  int exp_len, exp_wait;
  bit exp_rej;

  always @(posedge clk) cyc <= cyc + 1;

  // byte port responder with random latency
  initial begin
    int lat = 0;
    forever begin
      @(negedge clk);
      spi_ack = 1'b0;
      if (spi_req) begin
        if (lat == 0) begin
          spi_ack = 1'b1;
          spi_rx  = 8'($urandom);
          if (got_n < 16) begin
            got_tx[got_n] = spi_tx;
            got_rx[got_n] = spi_rx;
          end
          got_n++;
          ack_cyc = cyc + 1;
          lat = int'($urandom % 3);
        end else lat--;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b, input bit c);
    exp_b[exp_len] = b;
    exp_c[exp_len] = c;
    exp_len++;
  endtask

  task automatic model(input int op, input logic [7:0] t, input logic [15:0] a, input logic [7:0] d);
    bit nar = (t == 8'h86);
    logic [7:0] pk = {a[12:8], 3'b000};
    logic [7:0] dd;
    exp_len = 0; exp_rej = 0; exp_wait = 0;
    case (op)
      0, 1: if (op == 1 && nar) exp_rej = 1;
            else begin
              dd = (t == 8'h40) ? ~d : d;
              if (nar) begin push(pk | 8'h02, 0); push(a[7:0], 0); push(dd, 0); end
              else begin push((op == 1) ? 8'h48 : 8'h40, 0); push(a[15:8], 0); push(a[7:0], 0); push(dd, 0); end
              exp_wait = (t == 8'h40 || t == 8'h41) ? 0 : WR;
            end
      2: if (nar) begin push(pk | 8'h01, 0); push(a[7:0], 0); push(8'h00, 1); end
         else for (int f = 0; f < 2; f++) begin
           push((f == 0) ? 8'h28 : 8'h20, 0); push(a[15:8], 0); push(a[7:0], 0); push(8'h00, 1);
         end
      3: begin
           if (nar) begin push(pk | 8'h06, 0); push(a[7:0], 0); push(d, 0); end
           else begin push(8'hC0, 0); push(a[15:8], 0); push(a[7:0], 0); push(d, 0); end
           exp_wait = WR;
         end
      4: if (nar) begin push(pk | 8'h05, 0); push(a[7:0], 0); push(8'h00, 1); end
         else begin push(8'hA0, 0); push(a[15:8], 0); push(a[7:0], 0); push(8'h00, 1); end
      5: begin
           push(8'hAC, 0); if (!nar) push(8'h80, 0); push(8'h04, 0); push(8'h00, 0);
           exp_wait = LONG;
         end
      6: begin
           push(8'hAC, 0);
           if (nar) begin push((d & 8'hE0) | 8'h07, 0); push(8'h00, 0); end
           else begin push((d & 8'h06) | 8'hE0, 0); push(8'h00, 0); push(8'h00, 0); end
           exp_wait = LONG;
         end
      7: if (nar) exp_rej = 1;
         else for (int s = 2; s >= 0; s--) begin
           push(8'h30, 0); push(8'h00, 0); push(8'(s), 0); push(8'h00, 1);
         end
      8: begin push(8'h4C, 0); push(a[15:8], 0); push(a[7:0], 0); push(8'h00, 0); exp_wait = PAGE; end
      9: begin push(a[15:8], 0); push(a[7:0], 0); push(d, 0); push(8'h00, 1); exp_wait = PAGE; end
      default: exp_rej = 1;
    endcase
  endtask

  function automatic string ftag(input int op, input logic [7:0] t);
    if ((op == 0 || op == 1) && t == 8'h40) return "R5";
    case (op)
      0, 1, 3, 4: return (t == 8'h86) ? "R2" : "R1";
      2: return "R3";
      5: return "R7";
      6: return "R8";
      7: return "R9";
      8: return "R10";
      9: return "R11";
      default: return "R4";
    endcase
  endfunction

  function automatic string wtag(input int op);
    case (op)
      5: return "R7";
      6: return "R8";
      8: return "R10";
      9: return "R11";
      default: return "R6";
    endcase
  endfunction

  task automatic run(input int op, input logic [7:0] t, input logic [15:0] a,
                     input logic [7:0] d, input bit poke);
    int guard = 0;
    bit ok;
    logic [23:0] exp_rd = '0;
    model(op, t, a, d);
    got_n = 0;
    @(negedge clk);
    start = 1'b1; op_i = 4'(op); tgt_i = t; addr_i = a; wd_i = d;
    @(negedge clk);
    start = 1'b0; op_i = 4'($urandom); addr_i = 16'($urandom); wd_i = 8'($urandom);
    if (poke && !exp_rej) begin
      @(negedge clk); start = 1'b1; // R12 start while busy must be ignored
      @(negedge clk); start = 1'b0;
    end
    while (!done && guard < 2000) begin @(negedge clk); guard++; end
    check(done, "R12", "done timeout", 32'(guard), 32'd0);
    if (!done) return;
    check(err == exp_rej, exp_rej ? "R4" : ftag(op, t), "err flag", 32'(err), 32'(exp_rej));
    if (exp_rej) begin
      check(got_n == 0 && guard == 1, "R4", "reject made transfers or late", 32'(got_n), 32'd0);
    end else begin
      check(got_n == exp_len, ftag(op, t), "frame length", 32'(got_n), 32'(exp_len));
      ok = (got_n == exp_len);
      for (int k = 0; k < exp_len && k < got_n; k++) begin
        if (got_tx[k] != exp_b[k]) begin
          ok = 0;
          $display("FAIL %s byte %0d of op %0d: actual %0h expected %0h",
                   ftag(op, t), k, op, got_tx[k], exp_b[k]);
        end
        if (exp_c[k]) exp_rd = {exp_rd[15:0], got_rx[k]};
      end
      n_run++; if (!ok) n_fail++;
      check(rdata == exp_rd, (op == 7) ? "R9" : (op == 9) ? "R11" : "R3",
            "rdata", 32'(rdata), 32'(exp_rd));
      check(cyc - ack_cyc == exp_wait, wtag(op), "post-write wait",
            32'(cyc - ack_cyc), 32'(exp_wait));
    end
    @(negedge clk);
    check(!done, "R12", "done longer than one cycle", 32'(done), 32'd0);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] tl [0:5];
    void'($urandom(32'd4242));
    tl[0] = 8'h86; tl[1] = 8'h40; tl[2] = 8'h41; tl[3] = 8'h38; tl[4] = 8'h20; tl[5] = 8'h13;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!spi_req && !done && !err && rdata == 0, "R13", "reset state",
          {spi_req, done, err, 5'd0, rdata}, 32'd0);
    for (int o = 0; o < 11; o++) begin
      run(o, 8'h38, 16'hA5C3, 8'h5A, o[0]);
      run(o, 8'h86, 16'h1B7E, 8'hF3, 1'b0);
    end
    run(0, 8'h40, 16'h0102, 8'h3C, 1'b0);
    run(1, 8'h40, 16'h0102, 8'hC3, 1'b0);
    run(1, 8'h41, 16'h0304, 8'h11, 1'b0);
    run(3, 8'h40, 16'h0506, 8'h77, 1'b0);
    run(15, 8'h38, 16'h0000, 8'h00, 1'b0);
    for (int i = 0; i < 80; i++)
      run(int'($urandom % 12), tl[$urandom % 6], 16'($urandom), 8'($urandom), 1'($urandom));
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule